// File: doc/BRIEF.md
# Multi-bit Field Extract Unit

This execution unit decodes and runs two custom bit-field extract instructions. Each one shifts the first source operand right and keeps between one and eight of its low bits. The register form takes its shift amount from the second source operand. The immediate form takes it from a five-bit field in the instruction word.

Each cycle the unit may receive an instruction word and two 32-bit operands, qualified by a valid strobe. One cycle later it produces a registered result with a valid pulse and the destination register index for writeback. If an instruction carries the custom-0 opcode but an unknown sub-function or nonzero reserved bits, the unit instead raises a one-cycle illegal pulse. Instructions with any other opcode do not concern the unit, and it ignores them without a response.

Top module: `fx_extract`

## Requirements
- R1: A legal instruction yields `resData = (srcA >> shamt) & ((1 << n) - 1)`, where `n` is the field width.
- R2: Instruction bits 28:26 hold the field width minus one, so codes 0..7 select widths of 1..8 bits.
- R3: Sub-function bits 14:12 equal to 3'b000 select the register form, and the shift amount is `srcB[4:0]`. The upper bits of `srcB` have no effect.
- R4: Sub-function bits 14:12 equal to 3'b100 select the immediate form, and the shift amount is instruction bits 24:20 (0..31). `srcB` has no effect.
- R5: The unit responds only to instructions whose bits 6:0 equal 7'b0001011. For any other opcode, neither `resValid` nor `resIllegal` is raised.
- R6: A custom-0 instruction with any of bits 31:29 or bit 25 set raises `resIllegal` and does not raise `resValid`.
- R7: A custom-0 instruction whose sub-function is neither 3'b000 nor 3'b100 raises `resIllegal` and does not raise `resValid`.
- R8: `resValid` and `resIllegal` are single-cycle pulses, asserted in the cycle after the input was accepted. They are never asserted together.
- R9: `resData` and `resRd` hold their values in every cycle that produces no valid result.
- R10: `resRd` carries instruction bits 11:7 of the instruction that produced the result.
- R11: While reset is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| srcA | input | 32 | Operand holding the field |
| srcB | input | 32 | Operand whose low 5 bits give the register-form shift |
| resValid | output | 1 | Result valid pulse |
| resIllegal | output | 1 | Illegal-encoding pulse |
| resData | output | 32 | Extracted field, zero-extended |
| resRd | output | 5 | Destination register index |

## Verification
The hardest condition to reach is a rejected instruction that arrives right after a legal one. If the unit updated its result register at the wrong moment, the stale data would expose it. The stimulus therefore interleaves legal extracts with reserved-bit, unknown sub-function and foreign-opcode words, back to back and with idle gaps. It sets the shift amounts to 31 and the widths to 8 so that an over-wide mask or a stray shift bit shows up. A behavioural model predicts every output on every cycle.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int DATA_W    = 32;
  localparam int MAX_FIELD = 8;
  localparam int SIZE_W    = $clog2(MAX_FIELD);
  localparam int SHAMT_W   = $clog2(DATA_W);
  localparam int RD_W      = 5;

  localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;
  localparam logic [2:0] F3_REG      = 3'b000;
  localparam logic [2:0] F3_IMM      = 3'b100;

  typedef struct packed {
    logic loadRes;
    logic useImm;
    logic flagIllegal;
  } fxCtrl_t;
endpackage

// File: rtl/fx_ctrl.sv
module fx_ctrl
  import fx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instr,
  output fxCtrl_t     ctrl,
  output logic        resValid,
  output logic        resIllegal
);
  logic isCustom;
  logic rsvdSet;
  logic f3Reg;
  logic f3Imm;

  always_comb begin
    isCustom = (instr[6:0] == OPC_CUSTOM0);
    rsvdSet  = (|instr[31:29]) | instr[25];
    f3Reg    = (instr[14:12] == F3_REG);
    f3Imm    = (instr[14:12] == F3_IMM);
    ctrl.useImm      = f3Imm;
    ctrl.loadRes     = inValid & isCustom & ~rsvdSet & (f3Reg | f3Imm);
    ctrl.flagIllegal = inValid & isCustom & (rsvdSet | ~(f3Reg | f3Imm));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resIllegal <= 1'b0;
    end else begin
      resValid   <= ctrl.loadRes;
      resIllegal <= ctrl.flagIllegal;
    end
  end
endmodule

// File: rtl/fx_dpath.sv
module fx_dpath
  import fx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  fxCtrl_t             ctrl,
  input  logic [31:0]         instr,
  input  logic [DATA_W-1:0]   srcA,
  input  logic [SHAMT_W-1:0]  shamtReg,
  output logic [DATA_W-1:0]   resData,
  output logic [RD_W-1:0]     resRd
);
  logic [SHAMT_W-1:0]   shamt;
  logic [SIZE_W-1:0]    sizeCode;
  logic [DATA_W-1:0]    shifted;
  logic [MAX_FIELD-1:0] mask;
  logic [DATA_W-1:0]    field;

  assign sizeCode = instr[28:26];
  assign shamt    = ctrl.useImm ? instr[20 +: SHAMT_W] : shamtReg;
  assign shifted  = srcA >> shamt;

  for (genvar i = 0; i < MAX_FIELD; i++) begin : g_mask
    assign mask[i] = (SIZE_W'(i) <= sizeCode);
  end

  assign field = {{(DATA_W-MAX_FIELD){1'b0}}, shifted[MAX_FIELD-1:0] & mask};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      resRd   <= '0;
    end else if (ctrl.loadRes) begin
      resData <= field;
      resRd   <= instr[11:7];
    end
  end
endmodule

// File: rtl/fx_extract.sv
module fx_extract
  import fx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instr,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  output logic        resValid,
  output logic        resIllegal,
  output logic [31:0] resData,
  output logic [4:0]  resRd
);
  fxCtrl_t ctrl;

  fx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .instr      (instr),
    .ctrl       (ctrl),
    .resValid   (resValid),
    .resIllegal (resIllegal)
  );

  fx_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .instr    (instr),
    .srcA     (srcA),
    .shamtReg (srcB[SHAMT_W-1:0]),
    .resData  (resData),
    .resRd    (resRd)
  );
endmodule

// File: rtl/fx_extract_chk.sv
module fx_extract_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] instr,
  input logic [31:0] srcA,
  input logic [31:0] srcB,
  input logic        resValid,
  input logic        resIllegal,
  input logic [31:0] resData,
  input logic [4:0]  resRd
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && resIllegal)); // R8
  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> $past(inValid)); // R8
  AST_ILLEGAL_OWN_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resIllegal) |-> ($past(inValid) && $past(instr[6:0]) == 7'b0001011)); // R5
  AST_FIELD_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resData[31:8] == 24'd0)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> ($stable(resData) && $stable(resRd))); // R9
  AST_RD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> resRd == $past(instr[11:7])); // R10
endmodule

bind fx_extract fx_extract_chk u_chk (.*);

// File: tb/fx_extract_tb.sv
module fx_extract_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic        resValid;
  logic        resIllegal;
  logic [31:0] resData;
  logic [4:0]  resRd;

  int total = 0;
  int bad = 0;

  // reference state
  bit          eV = 0, eI = 0;
  logic [31:0] eD = '0;
  logic [4:0]  eR = '0;
  string       pendTag = "R11";

  always #2 clk = ~clk;

  fx_extract dut_i (.*);

  function automatic logic [31:0] mk(int width, int sh, logic [2:0] f3, int rd, logic [3:0] rsvd);
    logic [31:0] w;
    w = '0;
    w[31:29] = rsvd[3:1];
    w[28:26] = 3'(width - 1);
    w[25]    = rsvd[0];
    w[24:20] = 5'(sh);
    w[19:15] = 5'd3;
    w[14:12] = f3;
    w[11:7]  = 5'(rd);
    w[6:0]   = 7'b0001011;
    return w;
  endfunction

  task automatic compare(string tag);
    total++;
    if (resValid !== eV || resIllegal !== eI || resData !== eD || resRd !== eR) begin
      bad++;
      $display("FAIL %s: got v=%0b i=%0b d=%h rd=%0d, expected v=%0b i=%0b d=%h rd=%0d",
               tag, resValid, resIllegal, resData, resRd, eV, eI, eD, eR);
    end
  endtask

  task automatic step(bit v, logic [31:0] ins, logic [31:0] a, logic [31:0] b, string tag);
    int n;
    int sh;
    @(negedge clk);
    compare(pendTag);
    inValid = v; instr = ins; srcA = a; srcB = b;
    pendTag = tag;
    eV = 0; eI = 0;
    if (v && ins[6:0] == 7'b0001011) begin
      if ((ins[14:12] == 3'b000 || ins[14:12] == 3'b100) && ins[31:29] == 0 && !ins[25]) begin
        sh = (ins[14:12] == 3'b100) ? int'(ins[24:20]) : int'(b[4:0]);
        n  = int'(ins[28:26]) + 1;
        eV = 1;
        eD = (a >> sh) & ((32'd1 << n) - 1);
        eR = ins[11:7];
      end else begin
        eI = 1;
      end
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    inValid = 1'b1; instr = mk(8, 0, 3'b100, 5, 0); srcA = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (resValid !== 0 || resIllegal !== 0 || resData !== 0 || resRd !== 0) begin
      bad++;
      $display("FAIL R11: got v=%0b i=%0b d=%h rd=%0d, expected all zero", resValid, resIllegal, resData, resRd);
    end
    inValid = 0;
    rstN = 1'b1;
    // R4 immediate form, boundary shift 31, widths 1 and 8; srcB ignored
    step(1, mk(8, 31, 3'b100, 1, 0), 32'h8000_0000, 32'hFFFF_FFFF, "R4");
    step(1, mk(1, 0, 3'b100, 2, 0), 32'h0000_0003, 32'h0000_0010, "R4");
    step(1, mk(8, 4, 3'b100, 3, 0), 32'hDEAD_BEEF, 32'h0, "R1");
    // R3 register form, srcB upper bits ignored
    step(1, mk(8, 0, 3'b000, 4, 0), 32'hDEAD_BEEF, 32'hFFFF_FFE8, "R3");
    step(1, mk(3, 17, 3'b000, 5, 0), 32'h1234_5678, 32'h0000_0004, "R3");
    // R2 every width code
    for (int w = 1; w <= 8; w++) step(1, mk(w, 2, 3'b100, w, 0), 32'hFFFF_FFFF, 32'h0, "R2");
    // R6 reserved bits, right after a legal result (R9 hold)
    step(1, mk(4, 0, 3'b000, 9, 0), 32'h0000_00A5, 32'h0, "R1");
    step(1, mk(4, 0, 3'b000, 10, 4'b0001), 32'hFFFF_FFFF, 32'h0, "R6");
    step(1, mk(4, 0, 3'b100, 11, 4'b1000), 32'hFFFF_FFFF, 32'h0, "R6");
    step(1, mk(4, 0, 3'b100, 12, 4'b0100), 32'hFFFF_FFFF, 32'h0, "R6");
    // R7 unknown sub-functions
    for (int f = 1; f < 8; f++)
      if (f != 4) step(1, mk(5, 1, 3'(f), 13, 0), 32'hFFFF_FFFF, 32'h0, "R7");
    // R5 foreign opcodes
    step(1, mk(8, 0, 3'b000, 14, 0) ^ 32'h1, 32'hFFFF_FFFF, 32'h0, "R5");
    step(1, mk(8, 0, 3'b100, 15, 0) ^ 32'h20, 32'hFFFF_FFFF, 32'h0, "R5");
    // R8 idle gaps, R9 hold, R10 rd
    step(0, mk(8, 0, 3'b100, 16, 0), 32'h5555_5555, 32'h0, "R8");
    step(1, mk(6, 8, 3'b100, 31, 0), 32'hCAFE_F00D, 32'h0, "R10");
    step(0, 32'h0, 32'h0, 32'h0, "R9");
    step(0, 32'h0, 32'h0, 32'h0, "R9");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ins;
      ins = $urandom;
      ins[6:0] = ($urandom_range(0, 3) != 0) ? 7'b0001011 : ins[6:0];
      if ($urandom_range(0, 2) != 0) begin ins[31:29] = 0; ins[25] = 0; end
      if ($urandom_range(0, 2) != 0) ins[14:12] = $urandom_range(0, 1) ? 3'b100 : 3'b000;
      step(1'($urandom_range(0, 3) != 0), ins, $urandom, $urandom, "R1");
    end
    step(0, 32'h0, 32'h0, 32'h0, "R8");
    @(negedge clk);
    compare(pendTag);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule